// File: doc/BRIEF.md
# Four-Channel DMA Bus Arbiter with Burst and Cycle-Steal Modes

This block decides, every clock cycle, which master owns a single shared bus: one of four DMA channels or the CPU. Each channel presents a request, a bus-mode setting (burst or cycle-steal), a flag marking its request source as a serial-type peripheral, a transfer-size code and a loadable count of remaining transfers. The arbiter registers one grant per cycle. It decrements the count of the channel it serves and pulses that channel's done flag on its last unit. It also reports the transfer size of the slot it granted.

Channel 0 has the highest priority and channel 3 the lowest. A channel in burst mode holds the bus, and the CPU gets no slots while any bursting channel still has work. A higher-priority channel can still cut in at any slot. A burst-mode intruder runs to completion before the interrupted channel resumes. A cycle-steal intruder takes one slot per request, and the interrupted burst continues in any slot where the intruder is not requesting. When no burst is in progress, each cycle-steal slot is followed by one CPU slot.

The controller is a three-state machine on the owner of the current slot. **ST_CPU** means the CPU owns it, **ST_BURST** means a channel owns it in burst mode, and **ST_STEAL** means a channel owns it in cycle-steal mode. The transitions are as follows:
- From ST_CPU or ST_BURST, the machine goes to ST_BURST or ST_STEAL when some channel is eligible, according to the winner's effective mode. Otherwise it goes to ST_CPU.
- From ST_STEAL, the machine goes to ST_BURST or ST_STEAL only if an eligible channel is holding a burst. Otherwise it goes to ST_CPU, which is the return gap.

Top module: `dma_bus_arbiter`

## Requirements
- R1: A synchronous active-high reset clears every count and the burst-hold state. After the first clock edge with `rst` high, `cpu_gnt` is 1 and `ch_gnt`, `ch_done` and `xfer_size` are 0.
- R2: Grants are registered. The decision made from the inputs in one cycle shows on the outputs after the next rising edge. Exactly one of the four `ch_gnt` bits and `cpu_gnt` is high in every cycle. `cpu_gnt` is high whenever no channel is eligible. A channel is eligible when its request is high, its count is nonzero and it is not being loaded.
- R3: Among eligible channels, the lowest channel index wins.
- R4: A channel granted in burst mode keeps the bus in consecutive slots while it stays eligible. No CPU slot is given while any eligible channel holds a burst.
- R5: When a higher-priority channel in burst mode becomes eligible during another channel's burst, it takes the next slot. It keeps the bus until its count reaches zero, and the interrupted channel then resumes in the following slot.
- R6: When a higher-priority cycle-steal channel requests during another channel's burst, it wins every slot in which it is eligible. The bursting channel gets every slot in which the intruder is not eligible, with no CPU slot in between.
- R7: When no eligible channel holds a burst, each cycle-steal slot is followed by exactly one CPU slot before any channel is granted again.
- R8: A channel whose `ch_serial` bit is 1 is treated as cycle-steal even when its `ch_burst` bit is 1.
- R9: Each grant decrements the served channel's count by one. `ch_done` for that channel is high in the same cycle as the grant that brings its count to zero. A channel with a zero count is never granted, even while it requests.
- R10: The count of a channel that has been preempted stays unchanged until that channel is granted again.
- R11: When `ch_load[i]` is high, the count of channel i takes `ch_load_val[i]` at the next edge, and channel i is excluded from that cycle's arbitration.
- R12: `xfer_size` shows the size code of the granted channel: 0 for 8 bits, 1 for 16 bits, 2 for 32 bits. Code 3 is reported as 2. `xfer_size` is 0 in a CPU slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req | input | 4 | Transfer request per channel |
| ch_burst | input | 4 | Bus mode per channel: 1 burst, 0 cycle-steal |
| ch_serial | input | 4 | Serial-type request source; forces cycle-steal |
| ch_size | input | 8 | Two-bit size code per channel, channel i at bits [2i+1:2i] |
| ch_load | input | 4 | Load strobe for each channel's count |
| ch_load_val | input | 64 | Count to load, channel i at bits [16i+15:16i] |
| ch_gnt | output | 4 | Registered channel grant, one-hot or zero |
| cpu_gnt | output | 1 | Registered CPU grant |
| ch_done | output | 4 | One-cycle pulse with the grant of a channel's last unit |
| xfer_size | output | 2 | Size code of the granted slot |
| ch_remain | output | 64 | Remaining count per channel, same packing as `ch_load_val` |

## Verification
Directed sequences each separate one rule. A lone burst channel shows that the bus is held with no CPU slots. Burst-on-burst preemption shows that the intruder runs to the end while the victim's count stays frozen. A cycle-steal intruder toggled against a running burst shows slot-by-slot hand-back with no CPU gap. A lone cycle-steal channel, and a burst channel forced by its serial flag, show the one-cycle CPU return. Size codes including the reserved one, loads coinciding with requests, and requests on exhausted channels cover the remaining corners. A long run with random requests, modes, sizes and loads on all four channels then exercises mixed priority orderings against a bench model of the arbitration rules.

// File: rtl/dma_arb_pkg.sv
`timescale 1ns/1ps
package dma_arb_pkg;

    // Owner of the current bus slot.
    typedef enum logic [1:0] {
        ST_CPU   = 2'd0,
        ST_BURST = 2'd1,
        ST_STEAL = 2'd2
    } bus_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_RSVD = 2'd3;

    // Reserved code is reported as a full word.
    function automatic logic [1:0] size_norm(input logic [1:0] code);
        return (code == SZ_RSVD) ? SZ_WORD : code;
    endfunction

endpackage

// File: rtl/dma_prio_pick.sv
`timescale 1ns/1ps
module dma_prio_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  elig,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Fixed priority: the lowest index wins.
    always_comb begin
        any = |elig;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/dma_chan_count.sv
`timescale 1ns/1ps
module dma_chan_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             req,
    input  logic             serve,
    output logic [CNT_W-1:0] cnt,
    output logic             elig,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // A channel being loaded sits out this cycle.
    assign elig = req && (cnt != '0) && !load;
    assign last = (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (serve) begin
            cnt <= cnt - ONE;
        end
    end

endmodule

// File: rtl/dma_bus_fsm.sv
`timescale 1ns/1ps
module dma_bus_fsm
    import dma_arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  elig,
    input  logic [N-1:0]  burst_eff,
    input  logic [N-1:0]  last,
    input  logic          pick_any,
    input  logic [IW-1:0] pick_idx,
    output logic          take,
    output logic [N-1:0]  serve,
    output bus_state_e    state_q,
    output logic [N-1:0]  hold_q,
    output logic [N-1:0]  gnt_q,
    output logic          cpu_q,
    output logic [N-1:0]  done_q
);

    bus_state_e   state_d;
    logic         held_any;
    logic         win_burst;
    logic [N-1:0] hold_d;

    assign held_any  = |(hold_q & elig);
    assign win_burst = burst_eff[pick_idx];

    // Next owner of the bus.
    always_comb begin
        state_d = ST_CPU;
        unique case (state_q)
            ST_CPU, ST_BURST: begin
                if (pick_any) begin
                    state_d = win_burst ? ST_BURST : ST_STEAL;
                end
            end
            ST_STEAL: begin
                // Gap to the CPU unless a burst is still holding the bus.
                if (pick_any && held_any) begin
                    state_d = win_burst ? ST_BURST : ST_STEAL;
                end
            end
            default: state_d = ST_CPU;
        endcase
    end

    assign take  = (state_d != ST_CPU);
    assign serve = take ? (N'(1) << pick_idx) : '0;

    // Burst ownership survives preemption while the owner stays eligible.
    always_comb begin
        hold_d = hold_q & elig;
        if (take) begin
            if (last[pick_idx]) begin
                hold_d[pick_idx] = 1'b0;
            end else if (win_burst) begin
                hold_d[pick_idx] = 1'b1;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CPU;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            gnt_q  <= '0;
            cpu_q  <= 1'b1;
            done_q <= '0;
        end else begin
            hold_q <= hold_d;
            gnt_q  <= serve;
            cpu_q  <= !take;
            done_q <= serve & last;
        end
    end

endmodule

// File: rtl/dma_bus_arbiter.sv
`timescale 1ns/1ps
module dma_bus_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       ch_req,
    input  logic [NCH-1:0]       ch_burst,
    input  logic [NCH-1:0]       ch_serial,
    input  logic [2*NCH-1:0]     ch_size,
    input  logic [NCH-1:0]       ch_load,
    input  logic [NCH*CNT_W-1:0] ch_load_val,
    output logic [NCH-1:0]       ch_gnt,
    output logic                 cpu_gnt,
    output logic [NCH-1:0]       ch_done,
    output logic [1:0]           xfer_size,
    output logic [NCH*CNT_W-1:0] ch_remain
);

    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0] elig;
    logic [NCH-1:0] last;
    logic [NCH-1:0] serve;
    logic [NCH-1:0] burst_eff;
    logic [NCH-1:0] hold_q;
    logic           pick_any;
    logic [IW-1:0]  pick_idx;
    logic           take;
    bus_state_e     fsm_state;
    logic [1:0]     size_q;

    // Serial-type sources are always cycle-steal.
    assign burst_eff = ch_burst & ~ch_serial;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chan
            dma_chan_count #(.CNT_W(CNT_W)) u_cnt (
                .clk      (clk),
                .rst      (rst),
                .load     (ch_load[g]),
                .load_val (ch_load_val[g*CNT_W +: CNT_W]),
                .req      (ch_req[g]),
                .serve    (serve[g]),
                .cnt      (ch_remain[g*CNT_W +: CNT_W]),
                .elig     (elig[g]),
                .last     (last[g])
            );
        end
    endgenerate

    dma_prio_pick #(.N(NCH), .IW(IW)) u_pick (
        .elig (elig),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    dma_bus_fsm #(.N(NCH), .IW(IW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .elig      (elig),
        .burst_eff (burst_eff),
        .last      (last),
        .pick_any  (pick_any),
        .pick_idx  (pick_idx),
        .take      (take),
        .serve     (serve),
        .state_q   (fsm_state),
        .hold_q    (hold_q),
        .gnt_q     (ch_gnt),
        .cpu_q     (cpu_gnt),
        .done_q    (ch_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q <= SZ_BYTE;
        end else if (take) begin
            size_q <= size_norm(ch_size[2*pick_idx +: 2]);
        end else begin
            size_q <= SZ_BYTE;
        end
    end

    assign xfer_size = size_q;

endmodule

// File: rtl/dma_arb_checker.sv
`timescale 1ns/1ps
module dma_arb_checker
    import dma_arb_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NCH-1:0]       ch_gnt,
    input logic                 cpu_gnt,
    input logic [NCH-1:0]       ch_done,
    input logic [NCH-1:0]       ch_load,
    input logic [NCH*CNT_W-1:0] ch_remain,
    input logic [NCH-1:0]       elig,
    input logic [NCH-1:0]       hold_q,
    input bus_state_e           state_q
);

    AST_RESET_CPU: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cpu_gnt && ch_gnt == '0 && ch_done == '0)); // R1

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $countones({ch_gnt, cpu_gnt}) == 1); // R2

    AST_STEAL_GAP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STEAL && (hold_q & elig) == '0) |=> cpu_gnt); // R7

    AST_DONE_ON_GRANT: assert property (@(posedge clk) disable iff (rst)
        (ch_done & ~ch_gnt) == '0); // R9

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chk
            AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
                ch_gnt[g] |-> (ch_remain[g*CNT_W +: CNT_W]
                               == $past(ch_remain[g*CNT_W +: CNT_W]) - CNT_W'(1))); // R9

            AST_NO_ZERO_GNT: assert property (@(posedge clk) disable iff (rst)
                ch_gnt[g] |-> ($past(ch_remain[g*CNT_W +: CNT_W]) != '0)); // R9

            AST_LOAD_NO_GNT: assert property (@(posedge clk) disable iff (rst)
                ch_load[g] |=> !ch_gnt[g]); // R11
        end
    endgenerate

endmodule

bind dma_bus_arbiter dma_arb_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ch_gnt    (ch_gnt),
    .cpu_gnt   (cpu_gnt),
    .ch_done   (ch_done),
    .ch_load   (ch_load),
    .ch_remain (ch_remain),
    .elig      (elig),
    .hold_q    (hold_q),
    .state_q   (fsm_state)
);

// File: tb/sim_dma_bus_arbiter.sv
`timescale 1ns/1ps
module sim_dma_bus_arbiter;

    localparam int NCH   = 4;
    localparam int CNT_W = 16;

    logic                 clk = 1'b0;
    logic                 rst;
    logic [NCH-1:0]       ch_req, ch_burst, ch_serial, ch_load;
    logic [2*NCH-1:0]     ch_size;
    logic [NCH*CNT_W-1:0] ch_load_val;
    logic [NCH-1:0]       ch_gnt, ch_done;
    logic                 cpu_gnt;
    logic [1:0]           xfer_size;
    logic [NCH*CNT_W-1:0] ch_remain;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag   = "R1";

    // Bench model of the arbitration rules.
    int unsigned m_cnt [NCH];
    bit          m_hold[NCH];
    int          m_state;       // 0 cpu, 1 burst, 2 steal
    bit [NCH-1:0] m_gnt, m_done;
    bit          m_cpu;
    bit [1:0]    m_size;

    always #4 clk = ~clk;

    dma_bus_arbiter #(.NCH(NCH), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .ch_req(ch_req), .ch_burst(ch_burst),
        .ch_serial(ch_serial), .ch_size(ch_size), .ch_load(ch_load),
        .ch_load_val(ch_load_val), .ch_gnt(ch_gnt), .cpu_gnt(cpu_gnt),
        .ch_done(ch_done), .xfer_size(xfer_size), .ch_remain(ch_remain)
    );

    function automatic bit [1:0] norm(input bit [1:0] c);
        return (c == 2'd3) ? 2'd2 : c;
    endfunction

    task automatic model_step();
        bit el[NCH];
        bit nh[NCH];
        int w = -1;
        bit held = 0;
        bit take, beff, lst;
        for (int i = 0; i < NCH; i++)
            el[i] = ch_req[i] && m_cnt[i] != 0 && !ch_load[i];
        for (int i = NCH - 1; i >= 0; i--) if (el[i]) w = i;
        for (int i = 0; i < NCH; i++) if (m_hold[i] && el[i]) held = 1;
        take = (w >= 0) && (held || m_state != 2);
        for (int i = 0; i < NCH; i++) nh[i] = m_hold[i] && el[i];
        beff = 0; lst = 0;
        if (take) begin
            beff = ch_burst[w] && !ch_serial[w];
            lst  = (m_cnt[w] == 1);
            if (lst) nh[w] = 0;
            else if (beff) nh[w] = 1;
        end
        for (int i = 0; i < NCH; i++) begin
            if (ch_load[i]) m_cnt[i] = ch_load_val[i*CNT_W +: CNT_W];
            else if (take && i == w) m_cnt[i] = m_cnt[i] - 1;
            m_hold[i] = nh[i];
        end
        m_gnt   = take ? (NCH'(1) << w) : '0;
        m_done  = (take && lst) ? (NCH'(1) << w) : '0;
        m_cpu   = !take;
        m_size  = take ? norm(ch_size[2*w +: 2]) : 2'd0;
        m_state = take ? (beff ? 1 : 2) : 0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_cnt[i] = 0; m_hold[i] = 0;
        end
        m_state = 0; m_gnt = '0; m_done = '0; m_cpu = 1; m_size = 0;
    endtask

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("ch_gnt", int'(ch_gnt), int'(m_gnt));
        chk("cpu_gnt", int'(cpu_gnt), int'(m_cpu));
        chk("ch_done", int'(ch_done), int'(m_done));
        chk("xfer_size", int'(xfer_size), int'(m_size));
        for (int i = 0; i < NCH; i++)
            chk("ch_remain", int'(ch_remain[i*CNT_W +: CNT_W]), int'(m_cnt[i]));
    endtask

    // One cycle: inputs already driven after a falling edge.
    task automatic cyc();
        if (rst) model_reset(); else model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        ch_load = '0;
    endtask

    task automatic load(input int ch, input int val);
        ch_load[ch] = 1'b1;
        ch_load_val[ch*CNT_W +: CNT_W] = CNT_W'(val);
    endtask

    task automatic idle();
        ch_req = '0; ch_burst = '0; ch_serial = '0; ch_load = '0;
    endtask

    initial begin
        #(8 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h00c0ffee);
        rst = 1'b1; ch_size = '0; ch_load_val = '0; idle();
        @(negedge clk);
        tag = "R1"; cyc(); cyc();
        rst = 1'b0;
        tag = "R1"; cyc();

        // R4: lone burst holds the bus, done on last unit (R9).
        tag = "R4 R9"; load(3, 4); ch_burst[3] = 1; ch_size[7:6] = 2'd1; cyc();
        ch_req[3] = 1; for (int k = 0; k < 7; k++) cyc();
        idle();

        // R5 / R10: burst intruder on running burst, victim count frozen.
        tag = "R5 R10"; load(3, 6); ch_burst = 4'b1010; cyc();
        ch_req[3] = 1; cyc(); cyc();
        load(1, 3); cyc();
        ch_req[1] = 1; for (int k = 0; k < 10; k++) cyc();
        idle();

        // R6: cycle-steal intruder toggling against a burst.
        tag = "R6 R10"; load(2, 10); load(0, 4); ch_burst = 4'b0100; cyc();
        ch_req[2] = 1; cyc(); cyc();
        for (int k = 0; k < 10; k++) begin
            ch_req[0] = (k % 3 != 2);
            cyc();
        end
        idle();

        // R7: lone cycle-steal channel gets a CPU slot after each transfer.
        tag = "R7"; load(1, 3); ch_size[3:2] = 2'd2; cyc();
        ch_req[1] = 1; for (int k = 0; k < 8; k++) cyc();
        idle();

        // R8: serial flag overrides the burst setting.
        tag = "R8"; load(2, 3); cyc();
        ch_req[2] = 1; ch_burst[2] = 1; ch_serial[2] = 1;
        for (int k = 0; k < 7; k++) cyc();
        idle();

        // R3 / R12: two cycle-steal channels, reserved size code.
        tag = "R3 R12"; load(0, 2); load(3, 2); ch_size = 8'b1100_0011; cyc();
        ch_req = 4'b1001; for (int k = 0; k < 9; k++) cyc();

        // R9 / R11: requests on empty channels, load while requesting.
        tag = "R9 R11"; ch_req = 4'b1111; cyc(); cyc();
        load(2, 2); cyc();
        for (int k = 0; k < 5; k++) cyc();
        idle();

        // R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12: constrained random mix.
        tag = "R2 R3 random";
        for (int k = 0; k < 4000; k++) begin
            for (int i = 0; i < NCH; i++) begin
                if ($urandom_range(99) < 6) load(i, int'($urandom_range(12)));
                if ($urandom_range(99) < 25) ch_req[i] = ($urandom_range(99) < 70);
                if ($urandom_range(99) < 3) ch_burst[i] = $urandom_range(1);
                if ($urandom_range(99) < 2) ch_serial[i] = ($urandom_range(3) == 0);
            end
            if ($urandom_range(99) < 5) ch_size = 8'($urandom);
            if (k == 2000) begin
                rst = 1'b1; tag = "R1"; cyc(); rst = 1'b0; tag = "R2 R3 random";
            end
            cyc();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule